// File: doc/BRIEF.md
# I2C Register Access Engine

This block is a bus target that never starts a transfer. It samples the serial clock and data lines with a fast system clock, at least 20 times the serial clock rate. It recognises START, repeated START and STOP. It answers one fixed 7-bit device address and turns each bus transaction into byte accesses on an internal 256-entry, 8-bit register space. A register file hangs off a simple port: an address, write data with a write strobe, a read strobe with combinational read data, and a one-cycle strobe for each STOP seen. The engine drives SDA only through an open-drain enable. When the enable is high, the pad pulls the line low.

A byte pointer persists across transactions and always holds one past the last register that was written or read. It wraps from FFh to 00h. A write transaction begins with the device address and a write direction bit. Its first byte loads the pointer, and every later byte is stored at the pointer, which then steps by one. A read transaction with no address phase returns data starting at the pointer. A write that carries only the register byte, followed by a repeated START and a read, gives a random read. The master acknowledges each byte it wants to continue a sequential read. A master NACK lets the engine release the line until STOP.

The state machine has these states: `ST_IDLE`, `ST_ADDR`, `ST_ADDR_ACK`, `ST_REG`, `ST_REG_ACK`, `ST_WDATA`, `ST_WDATA_ACK`, `ST_RDATA`, `ST_RACK` and `ST_SKIP`.
- STOP sends any state to `ST_IDLE`. START or repeated START sends any state to `ST_ADDR`.
- After eight address bits, `ST_ADDR` moves to `ST_ADDR_ACK` on a match and to `ST_SKIP` otherwise.
- `ST_ADDR_ACK` moves to `ST_REG` for a write, or loads the first byte and moves to `ST_RDATA` for a read.
- `ST_REG` moves to `ST_REG_ACK`, and `ST_REG_ACK` moves to `ST_WDATA`.
- `ST_WDATA` and `ST_WDATA_ACK` alternate for each further byte.
- `ST_RDATA` moves to `ST_RACK` after eight bits. `ST_RACK` returns to `ST_RDATA` on a master ACK and goes to `ST_SKIP` on a NACK.

Top module: `i2c_reg_slave`

## Requirements
- R1: The engine acknowledges the device address 69h, sent as address byte D2h for write or D3h for read, by pulling SDA low on the ninth clock. Any other address gets no acknowledge, and after it no write strobe and no pointer change occur until the next START or STOP.
- R2: In a matched write, the first byte after the address loads the pointer. Each later byte produces one `reg_we` pulse at `reg_addr` equal to the pointer, and the pointer then steps by one.
- R3: On the ninth clock of every byte it receives in a matched write (address, register and data bytes), the engine pulls SDA low.
- R4: A write frame that carries only the register byte, followed by a repeated START, sets the pointer and produces no `reg_we` pulse.
- R5: A read with no preceding address phase returns the register at the pointer, most significant bit first, and raises `reg_re` once per byte it fetches.
- R6: In a read, a master ACK fetches the next register at the advanced pointer. After a master NACK, the engine holds SDA released.
- R7: The pointer steps from FFh to 00h in both writes and reads.
- R8: The pointer persists across transactions and holds one past the last register written or read. A non-matching transaction leaves it untouched.
- R9: SDA rising while SCL is high is a STOP. It gives exactly one `stop_seen` pulse and returns the engine to idle. SDA falling while SCL is high is a START.
- R10: During reset, `sda_oe`, `reg_we` and `stop_seen` are low.
- R11: `sda_oe` changes only while SCL is low, except on a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| reg_addr | output | 8 | Register address, equal to the pointer |
| reg_wdata | output | 8 | Write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe; `reg_rdata` is captured in the same cycle |
| reg_rdata | input | 8 | Combinational read data for `reg_addr` |
| stop_seen | output | 1 | One-cycle pulse on each STOP |

## Verification
The assertions watch, on every cycle, how the pointer steps on each strobe, how the register byte loads it, that a STOP forces idle, that a missed address leaves SDA free, and that the SDA enable moves only while SCL is low. Whether the bytes read back match what was written earlier, whether current-address reads pick up where the last transfer stopped, and how the pointer wraps across separate transactions can only be shown by the bench's directed and random transaction sequences against its own register model.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } rs_state_t;

    localparam int LINE_SCL = 0;
    localparam int LINE_SDA = 1;

endpackage

// File: rtl/i2c_rs_sync.sv
module i2c_rs_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    for (genvar g = 0; g < W; g++) begin : g_line
        // chain[STAGES-1] is the synchronised level, chain[STAGES] its delayed copy
        logic [STAGES:0] chain;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-1:0], din[g]};
        end

        assign lvl[g]  = chain[STAGES-1];
        assign rise[g] = chain[STAGES-1] & ~chain[STAGES];
        assign fall[g] = ~chain[STAGES-1] & chain[STAGES];
    end
endmodule

// File: rtl/i2c_rs_cond.sv
module i2c_rs_cond (
    input  logic scl_lvl,
    input  logic sda_rise,
    input  logic sda_fall,
    output logic start,
    output logic stop
);
    // data may only move while the clock is low; a move under a high clock frames the transfer
    assign start = sda_fall & scl_lvl;
    assign stop  = sda_rise & scl_lvl;
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         DW          = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    output logic [DW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_we,
    output logic          reg_re,
    input  logic [DW-1:0] reg_rdata,
    output logic          stop_seen
);
    import i2c_rs_pkg::*;

    localparam int CW = $clog2(DW + 1);

    logic [1:0] lvl, rise, fall;
    logic       scl_lvl, sclr, sclf, sda_lvl, start, stop;

    rs_state_t     state, nstate;
    logic [CW-1:0] bcnt;
    logic [DW-1:0] sh, tx, ptr;
    logic          mack;
    logic          byte_done, addr_hit, frame_evt;

    i2c_rs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sda_i, scl_i}),
        .lvl  (lvl),
        .rise (rise),
        .fall (fall)
    );

    assign scl_lvl = lvl[LINE_SCL];
    assign sclr    = rise[LINE_SCL];
    assign sclf    = fall[LINE_SCL];
    assign sda_lvl = lvl[LINE_SDA];

    i2c_rs_cond u_cond (
        .scl_lvl (scl_lvl),
        .sda_rise(rise[LINE_SDA]),
        .sda_fall(fall[LINE_SDA]),
        .start   (start),
        .stop    (stop)
    );

    assign frame_evt = start | stop;
    assign byte_done = (bcnt == CW'(DW));
    assign addr_hit  = (sh[DW-1:1] == DEV_ADDR);

    // next-state decision
    always_comb begin
        nstate = state;
        if (stop) begin
            nstate = ST_IDLE;
        end else if (start) begin
            nstate = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:      nstate = ST_IDLE;
                ST_ADDR:      if (sclf && byte_done) nstate = addr_hit ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK:  if (sclf) nstate = sh[0] ? ST_RDATA : ST_REG;
                ST_REG:       if (sclf && byte_done) nstate = ST_REG_ACK;
                ST_REG_ACK:   if (sclf) nstate = ST_WDATA;
                ST_WDATA:     if (sclf && byte_done) nstate = ST_WDATA_ACK;
                ST_WDATA_ACK: if (sclf) nstate = ST_WDATA;
                ST_RDATA:     if (sclf && bcnt == CW'(DW - 1)) nstate = ST_RACK;
                ST_RACK:      if (sclf) nstate = mack ? ST_RDATA : ST_SKIP;
                ST_SKIP:      nstate = ST_SKIP;
                default:      nstate = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // shift registers, bit counter and pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt <= '0;
            sh   <= '0;
            tx   <= '0;
            ptr  <= '0;
            mack <= 1'b0;
        end else if (frame_evt) begin
            bcnt <= '0;
        end else begin
            unique case (state)
                ST_ADDR, ST_REG, ST_WDATA: begin
                    if (sclr) begin
                        sh   <= {sh[DW-2:0], sda_lvl};
                        bcnt <= bcnt + 1'b1;
                    end else if (sclf && byte_done) begin
                        bcnt <= '0;
                        if (state == ST_REG)   ptr <= sh;
                        if (state == ST_WDATA) ptr <= ptr + 1'b1;
                    end
                end
                ST_ADDR_ACK: begin
                    if (sclf && sh[0]) begin
                        tx   <= reg_rdata;
                        ptr  <= ptr + 1'b1;
                        bcnt <= '0;
                    end
                end
                ST_RDATA: begin
                    if (sclf) begin
                        tx   <= {tx[DW-2:0], 1'b1};
                        bcnt <= bcnt + 1'b1;
                    end
                end
                ST_RACK: begin
                    if (sclr) mack <= ~sda_lvl;
                    if (sclf && mack) begin
                        tx   <= reg_rdata;
                        ptr  <= ptr + 1'b1;
                        bcnt <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_oe = 1'b0;
        unique case (state)
            ST_ADDR_ACK, ST_REG_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA:                              sda_oe = ~tx[DW-1];
            default:                               sda_oe = 1'b0;
        endcase
        reg_we    = (state == ST_WDATA) && sclf && byte_done && !frame_evt;
        reg_re    = sclf && !frame_evt &&
                    (((state == ST_ADDR_ACK) && sh[0]) || ((state == ST_RACK) && mack));
        reg_addr  = ptr;
        reg_wdata = sh;
        stop_seen = stop;
    end

    // R2 R7
    // ptr_step_chk
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we || reg_re) |=> (ptr == $past(ptr) + 1'b1));

    // R4
    // reg_load_chk
    reg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REG && sclf && byte_done && !frame_evt) |=> (ptr == $past(sh) && !reg_we));

    // R9
    // stop_idle_chk
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_seen |=> (state == ST_IDLE));

    // R1
    // addr_miss_chk
    addr_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && sclf && byte_done && !addr_hit && !frame_evt) |=> (!sda_oe && state == ST_SKIP));

    // R11
    // sda_edge_chk
    sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sda_oe != $past(sda_oe)) && !$past(frame_evt)) |-> !scl_lvl);

endmodule

// File: tb/i2c_reg_slave_tb.sv
module i2c_reg_slave_tb;
    localparam int CLK_P = 10;
    localparam int Q     = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_bus;
    logic       sda_oe, reg_we, reg_re, stop_seen;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;

    logic [7:0] mem [256];
    logic [7:0] em  [256];
    logic [7:0] wbuf [8];
    logic [7:0] rbuf [8];
    logic [7:0] exp_ptr;
    int cmp_cnt = 0, err_cnt = 0;
    int we_cnt = 0, re_cnt = 0, stop_cnt = 0, edge_viol = 0;
    bit done = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    assign sda_bus   = sda_m & ~sda_oe;
    assign reg_rdata = mem[reg_addr];

    i2c_reg_slave u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_bus),
        .sda_oe   (sda_oe),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_we   (reg_we),
        .reg_re   (reg_re),
        .reg_rdata(reg_rdata),
        .stop_seen(stop_seen)
    );

    always @(posedge clk) begin
        if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
            we_cnt <= we_cnt + 1;
        end
        if (reg_re)    re_cnt   <= re_cnt + 1;
        if (stop_seen) stop_cnt <= stop_cnt + 1;
    end

    // R11 monitor: the enable must not move while the master holds SCL high
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && scl && sda_oe != oe_prev) edge_viol <= edge_viol + 1;
        oe_prev <= sda_oe;
    end

    function automatic logic [7:0] init_val(input int i);
        return 8'((i * 7 + 3) ^ 8'h5A);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        cmp_cnt++;
        if (!ok) begin
            err_cnt++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clock_bit(input bit v, output bit s);
        sda_m = v; tick(Q);
        scl = 1'b1; tick(Q);
        s = sda_bus; tick(Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        bit s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, s);
        ack = (s == 1'b0);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            b[i] = s;
        end
        clock_bit(!mack, s);
    endtask

    // write frame; the model follows only when the address matches
    task automatic i2c_write(input logic [6:0] dev, input logic [7:0] ra, input int n,
                             output bit addr_ack, output bit all_ack);
        bit a;
        bus_start();
        send_byte({dev, 1'b0}, addr_ack);
        all_ack = addr_ack;
        send_byte(ra, a); all_ack &= a;
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], a);
            all_ack &= a;
        end
        bus_stop();
        if (dev == 7'h69) begin
            for (int k = 0; k < n; k++) em[8'(ra + k)] = wbuf[k];
            exp_ptr = 8'(ra + n);
        end
    endtask

    // read of n bytes; random selects a register-address phase first
    task automatic i2c_read(input bit random, input logic [7:0] ra, input int n, input string req);
        bit a;
        int we0;
        we0 = we_cnt;
        bus_start();
        if (random) begin
            send_byte(8'hD2, a);
            send_byte(ra, a);
            bus_start();
            exp_ptr = ra;
        end
        send_byte(8'hD3, a);
        check(a, "R1 read addr ack", a, 1);
        for (int k = 0; k < n; k++) recv_byte(k < n - 1, rbuf[k]);
        check(sda_oe == 1'b0, "R6 released after NACK", sda_oe, 0);
        bus_stop();
        if (random) check(we_cnt == we0, "R4 no store on random read", we_cnt, we0);
        for (int k = 0; k < n; k++)
            check(rbuf[k] == em[8'(exp_ptr + k)], req, rbuf[k], em[8'(exp_ptr + k)]);
        exp_ptr = 8'(exp_ptr + n);
    endtask

    initial begin
        bit aa, al;
        int we0, st0, re0;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) begin
            mem[i] = init_val(i);
            em[i]  = init_val(i);
        end
        exp_ptr = 8'h00;

        tick(5);
        // R10
        check(sda_oe == 1'b0 && reg_we == 1'b0 && stop_seen == 1'b0, "R10 reset outputs",
              {sda_oe, reg_we, stop_seen}, 0);
        rst_n = 1'b1;
        tick(5);

        // R2 R3 R9 directed write
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        st0 = stop_cnt; we0 = we_cnt;
        i2c_write(7'h69, 8'h20, 3, aa, al);
        check(aa && al, "R3 ack every byte", al, 1);
        check(aa, "R1 address 69h acked", aa, 1);
        check(we_cnt == we0 + 3, "R2 write strobes", we_cnt - we0, 3);
        for (int k = 0; k < 3; k++) check(mem[8'h20 + k] == wbuf[k], "R2 stored data", mem[8'h20 + k], wbuf[k]);
        check(stop_cnt == st0 + 1, "R9 one stop pulse", stop_cnt - st0, 1);

        // R5 R8 current-address read after a write
        re0 = re_cnt;
        i2c_read(1'b0, 8'h00, 1, "R5 current address read");
        check(re_cnt == re0 + 1, "R5 read strobe", re_cnt - re0, 1);

        // R4 R6 random sequential read
        i2c_read(1'b1, 8'h10, 4, "R6 sequential read");

        // R1 R8 foreign address is ignored
        wbuf[0] = 8'hEE; wbuf[1] = 8'hDD;
        we0 = we_cnt;
        i2c_write(7'h68, 8'h40, 2, aa, al);
        check(!aa, "R1 foreign address NACK", aa, 0);
        check(we_cnt == we0, "R1 no store after miss", we_cnt - we0, 0);
        check(mem[8'h40] == em[8'h40], "R1 register untouched", mem[8'h40], em[8'h40]);
        i2c_read(1'b0, 8'h00, 1, "R8 pointer kept over miss");

        // R1 foreign read address
        bus_start();
        send_byte(8'hD7, aa);
        bus_stop();
        check(!aa, "R1 foreign read NACK", aa, 0);

        // R7 write wrap
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
        i2c_write(7'h69, 8'hFE, 3, aa, al);
        check(mem[8'h00] == 8'hC3, "R7 write wrapped to 00h", mem[8'h00], 8'hC3);
        i2c_read(1'b0, 8'h00, 1, "R7 pointer at 01h after wrap");
        // R7 read wrap
        i2c_read(1'b1, 8'hFF, 3, "R7 read wrap");

        // random mix
        for (int it = 0; it < 14; it++) begin
            int op, n;
            logic [7:0] ra;
            op = $urandom % 3;
            n  = 1 + ($urandom % 4);
            ra = 8'($urandom);
            if (op == 0) begin
                for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
                i2c_write(7'h69, ra, n, aa, al);
                check(al, "R3 random write acks", al, 1);
                for (int k = 0; k < n; k++)
                    check(mem[8'(ra + k)] == wbuf[k], "R2 random write", mem[8'(ra + k)], wbuf[k]);
            end else if (op == 1) begin
                i2c_read(1'b1, ra, n, "R6 random read");
            end else begin
                i2c_read(1'b0, 8'h00, n, "R8 random current read");
            end
        end

        check(edge_viol == 0, "R11 enable moved with SCL high", edge_viol, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp_cnt, err_cnt);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            cmp_cnt++;
            err_cnt++;
            $display("FAIL watchdog actual=%0d expected=%0d", 180000, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp_cnt, err_cnt);
            $finish;
        end
    end
endmodule